// File: doc/BRIEF.md
# ADC Output Word Formatter

This block sits between a 10-bit converter core and the data pins of a converter. Each accepted sample comes with an above-range flag and a below-range flag. The block saturates the code when the sample is outside full scale and raises an out-of-range flag. It then codes the result as straight binary or as Gray code, depending on a static select pin.

Two test aids share the same output path:
- A checkerboard mode replaces every emitted word with alternating complementary patterns.
- A decimation mode keeps one accepted sample in every 32 and drops the rest.

All outputs come from registers, one cycle after the sample is taken.

Both data interfaces use valid/ready. A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The output word is handed over on an edge where `out_valid` and `out_ready` are both high.

The block holds one word of storage, so `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output word and flag stay frozen. A source that cannot stall has to keep `out_ready` high.

Top module: `adc_out_fmt`

## Requirements
- R1: An accepted sample with `in_over`=1 and `in_under`=0, with the pattern mode off, produces all data bits 1 before coding and `out_oor`=1.
- R2: An accepted sample with `in_under`=1 and `in_over`=0, with the pattern mode off, produces all data bits 0 before coding and `out_oor`=1.
- R3: An accepted sample with both range flags 0 and the pattern mode off gives `out_oor`=0. With `gray_sel`=0 it gives `out_data` equal to `in_data`.
- R4: With `gray_sel`=1, `out_data` is the saturated code c coded as c ^ (c >> 1). For example, a saturated high code gives 10'h200 and a saturated low code gives 10'h000.
- R5: With `pat_en`=1, the emitted words ignore the data, the range flags and `gray_sel`. The first word after reset or after `pat_en` rises is 10'b0101010101 (10'h155). Each following emitted word is the bitwise complement of the previous one (10'h2AA, 10'h155, ...), and `out_oor` is 0.
- R6: With `dec_en`=1, the first sample accepted after reset or after `dec_en` rises is emitted. After that, only every 32nd accepted sample is emitted; the other accepted samples produce no output word.
- R7: With `dec_en`=0, every accepted sample is emitted.
- R8: A sample accepted at clock edge k is presented on `out_valid`/`out_data`/`out_oor` right after edge k.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data` and `out_oor` hold their values.
- R10: After a synchronous reset, `out_valid`, `out_data` and `out_oor` are 0, `in_ready` is 1, and the pattern phase and decimation count are at their start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 10 | Raw binary sample |
| in_over | input | 1 | Sample above positive full scale |
| in_under | input | 1 | Sample below negative full scale |
| gray_sel | input | 1 | Static coding select: 0 binary, 1 Gray |
| pat_en | input | 1 | Checkerboard test pattern enable |
| dec_en | input | 1 | Keep one sample in 32 |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | 10 | Formatted output word |
| out_oor | output | 1 | Out-of-range flag for the word |

## Verification
Saturation and Gray coding fall in the same cycle whenever an out-of-range sample arrives while `gray_sel` is high. The bench sends above-range and below-range samples with Gray coding on, and expects the Gray form of the clamped code (10'h200 and 10'h000), not the clamped binary code.

A second collision is the test pattern overriding an out-of-range sample. Over-range samples are sent with `pat_en` high. The bench expects the checkerboard sequence with `out_oor` at 0.

Stalling and decimation both gate the output. They are exercised separately, with the output words compared against an index count kept in the bench.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned FMT_DATA_W = 10;
  localparam int unsigned FMT_DECIM_LOG2 = 5;

  typedef enum logic [1:0] {
    RNG_INSIDE = 2'd0,
    RNG_ABOVE  = 2'd1,
    RNG_BELOW  = 2'd2
  } range_e;
endpackage

// File: rtl/fmt_clamp.sv
module fmt_clamp
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = FMT_DATA_W
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              over,
  input  logic              under,
  output logic [DATA_W-1:0] code,
  output logic              oor
);
  range_e rng;

  // above-range wins if both flags are raised
  always_comb begin
    if (over)       rng = RNG_ABOVE;
    else if (under) rng = RNG_BELOW;
    else            rng = RNG_INSIDE;
  end

  always_comb begin
    unique case (rng)
      RNG_ABOVE: code = '1;
      RNG_BELOW: code = '0;
      default:   code = raw;
    endcase
    oor = (rng != RNG_INSIDE);
  end
endmodule

// File: rtl/fmt_coder.sv
module fmt_coder #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              gray_sel,
  input  logic [DATA_W-1:0] code_in,
  output logic [DATA_W-1:0] code_out
);
  logic [DATA_W-1:0] gray;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == DATA_W - 1) begin : g_top
      assign gray[i] = code_in[i];
    end else begin : g_low
      assign gray[i] = code_in[i] ^ code_in[i+1];
    end
  end

  assign code_out = gray_sel ? gray : code_in;
endmodule

// File: rtl/fmt_decim.sv
module fmt_decim #(
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_en,
  input  logic accept,
  output logic keep
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !dec_en) cnt <= '0;
    else if (accept)    cnt <= cnt + 1'b1;
  end

  assign keep = !dec_en || (cnt == '0);
endmodule

// File: rtl/fmt_pattern.sv
module fmt_pattern #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pat_en,
  input  logic              step,
  output logic [DATA_W-1:0] word
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || !pat_en) phase <= 1'b0;
    else if (step)      phase <= ~phase;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign word[i] = ((i % 2) == 0) ? ~phase : phase;
  end
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DATA_W = FMT_DATA_W,
  parameter int unsigned DECIM_LOG2 = FMT_DECIM_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_over,
  input  logic              in_under,
  input  logic              gray_sel,
  input  logic              pat_en,
  input  logic              dec_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_oor
);
  logic              accept;
  logic              keep;
  logic              emit;
  logic              rng_oor;
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] pat_word;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign emit     = accept && keep;

  fmt_clamp #(.DATA_W(DATA_W)) u_clamp (
    .raw(in_data), .over(in_over), .under(in_under),
    .code(clamped), .oor(rng_oor)
  );

  fmt_coder #(.DATA_W(DATA_W)) u_coder (
    .gray_sel(gray_sel), .code_in(clamped), .code_out(coded)
  );

  fmt_decim #(.CNT_W(DECIM_LOG2)) u_decim (
    .clk(clk), .rst(rst), .dec_en(dec_en), .accept(accept), .keep(keep)
  );

  fmt_pattern #(.DATA_W(DATA_W)) u_pattern (
    .clk(clk), .rst(rst), .pat_en(pat_en), .step(emit), .word(pat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_oor   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= pat_en ? pat_word : coded;
      out_oor   <= pat_en ? 1'b0 : rng_oor;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DECIM_LOG2 = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_over,
  input logic              in_under,
  input logic              gray_sel,
  input logic              pat_en,
  input logic              dec_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_oor
);
  logic                  acc;
  logic [DECIM_LOG2-1:0] seen;
  logic [DATA_W-1:0]     gray_top;

  assign acc      = in_valid && in_ready;
  assign gray_top = {1'b1, {(DATA_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || !dec_en) seen <= '0;
    else if (acc)       seen <= seen + 1'b1;
  end

  // R1
  above_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    acc && in_over && !in_under && !pat_en && !dec_en |=>
      out_valid && out_oor && (out_data == ($past(gray_sel) ? gray_top : {DATA_W{1'b1}})));

  // R2
  below_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    acc && in_under && !in_over && !pat_en && !dec_en |=>
      out_valid && out_oor && (out_data == '0));

  // R3
  inside_flag_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !in_over && !in_under && !pat_en && !dec_en |=> out_valid && !out_oor);

  // R5
  pattern_flag_chk: assert property (@(posedge clk) disable iff (rst)
    acc && pat_en && !dec_en |=> !out_oor);

  // R6
  decim_drop_chk: assert property (@(posedge clk) disable iff (rst)
    acc && dec_en && (seen != '0) |=> !out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_oor));

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !out_oor && (out_data == '0));

  wire unused_ok = ^in_data;
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DATA_W(DATA_W), .DECIM_LOG2(DECIM_LOG2)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_over(in_over), .in_under(in_under),
  .gray_sel(gray_sel), .pat_en(pat_en), .dec_en(dec_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_oor(out_oor)
);

// File: tb/test_adc_out_fmt.sv
module test_adc_out_fmt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       in_over = 1'b0;
  logic       in_under = 1'b0;
  logic       gray_sel = 1'b0;
  logic       pat_en = 1'b0;
  logic       dec_en = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;
  logic       out_oor;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_out_fmt i_adc_out_fmt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_over(in_over), .in_under(in_under),
    .gray_sel(gray_sel), .pat_en(pat_en), .dec_en(dec_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_oor(out_oor)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] to_gray(input logic [9:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic push_chk(input string req, input logic [9:0] d, input logic ov,
                          input logic un, input logic [9:0] exp_d, input logic exp_oor);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_over = ov; in_under = un;
    @(negedge clk);
    in_valid = 1'b0; in_over = 1'b0; in_under = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " data"}, 32'(out_data), 32'(exp_d));
    chk({req, " oor"}, 32'(out_oor), 32'(exp_oor));
  endtask

  task automatic t_reset();
    chk("R10 valid", 32'(out_valid), 32'd0);
    chk("R10 data", 32'(out_data), 32'd0);
    chk("R10 oor", 32'(out_oor), 32'd0);
    chk("R10 ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_binary();
    gray_sel = 1'b0;
    push_chk("R3 R8 mid", 10'h1A5, 1'b0, 1'b0, 10'h1A5, 1'b0);
    push_chk("R3 zero", 10'h000, 1'b0, 1'b0, 10'h000, 1'b0);
    push_chk("R3 top", 10'h3FF, 1'b0, 1'b0, 10'h3FF, 1'b0);
    push_chk("R1 above", 10'h012, 1'b1, 1'b0, 10'h3FF, 1'b1);
    push_chk("R2 below", 10'h3C0, 1'b0, 1'b1, 10'h000, 1'b1);
  endtask

  task automatic t_gray();
    @(negedge clk); gray_sel = 1'b1;
    push_chk("R4 plain", 10'h2B5, 1'b0, 1'b0, to_gray(10'h2B5), 1'b0);
    push_chk("R4 plain2", 10'h0F0, 1'b0, 1'b0, to_gray(10'h0F0), 1'b0);
    push_chk("R4 R1 above", 10'h055, 1'b1, 1'b0, 10'h200, 1'b1);
    push_chk("R4 R2 below", 10'h2AA, 1'b0, 1'b1, 10'h000, 1'b1);
    @(negedge clk); gray_sel = 1'b0;
  endtask

  task automatic t_pattern();
    @(negedge clk); pat_en = 1'b1;
    push_chk("R5 w0", 10'h3FF, 1'b1, 1'b0, 10'h155, 1'b0);
    push_chk("R5 w1", 10'h000, 1'b0, 1'b1, 10'h2AA, 1'b0);
    @(negedge clk); gray_sel = 1'b1;
    push_chk("R5 w2 gray", 10'h123, 1'b0, 1'b0, 10'h155, 1'b0);
    push_chk("R5 w3 gray", 10'h321, 1'b1, 1'b0, 10'h2AA, 1'b0);
    @(negedge clk); pat_en = 1'b0; gray_sel = 1'b0;
    @(negedge clk); pat_en = 1'b1;
    push_chk("R5 restart", 10'h001, 1'b0, 1'b0, 10'h155, 1'b0);
    @(negedge clk); pat_en = 1'b0;
  endtask

  task automatic t_stream(input string req, input int n);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        logic exp_v;
        exp_v = dec_en ? (((i - 1) % 32) == 0) : 1'b1;
        chk({req, " valid"}, 32'(out_valid), 32'(exp_v));
        if (exp_v) chk({req, " data"}, 32'(out_data), 32'(i - 1));
      end
      if (i < n) begin
        in_valid = 1'b1; in_data = 10'(i);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_decim();
    t_stream("R7 every", 6);
    @(negedge clk); dec_en = 1'b1;
    t_stream("R6 one-in-32", 70);
    @(negedge clk); dec_en = 1'b0;
    @(negedge clk); dec_en = 1'b1;
    push_chk("R6 reentry", 10'h077, 1'b0, 1'b0, 10'h077, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 10'h0AB;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 second dropped", 32'(out_valid), 32'd0);
    @(negedge clk); dec_en = 1'b0;
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 10'h111;
    @(negedge clk);
    chk("R8 R9 first", 32'(out_data), 32'h111);
    chk("R9 ready low", 32'(in_ready), 32'd0);
    in_data = 10'h222;
    repeat (3) @(negedge clk);
    chk("R9 held valid", 32'(out_valid), 32'd1);
    chk("R9 held data", 32'(out_data), 32'h111);
    chk("R9 still low", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 drained valid", 32'(out_valid), 32'd1);
    chk("R9 drained data", 32'(out_data), 32'h222);
    @(negedge clk);
    chk("R9 empty", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_binary();
    t_gray();
    t_pattern();
    t_decim();
    t_stall();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule